// File: doc/BRIEF.md
# Serial Flash Security Register Reader

This block is the slave side of a serial flash that serves one command: a read of the one-time security register. A host selects the device by pulling chip select low and clocks an 8-bit command in on the serial input. If the command is the security-register read, the block ignores a fixed run of filler bytes that follow it. It then shifts the register contents out on the serial output, most significant bit first, starting with byte 0.

The serial clock and the other pins are sampled by a faster system clock, and their edges are found by comparing each sample with the one before it. Input bits are taken on rising serial-clock edges. The output bit changes on falling edges, so the host can sample it on its next rising edge. Clocking past the last register byte returns all ones, and the read never wraps around. Raising chip select ends the transfer at any point and floats the output.

The register contents come from one of two sources, chosen by a parameter. One is a flat input bus, for a register held elsewhere on the chip. The other is a pattern computed at elaboration from a seed, which serves as a fixed identifier.

Top module: `secreg_spi_reader`

## Requirements
- R1: While `cs_n` is low, `si` is taken MSB first on each rising `sck` edge. The first eight bits form the command, and the value 0x77 (parameter `OPCODE`) selects the register read.
- R2: After a matching command, `so_en` stays low through `DUMMY_BYTES` (default 3, i.e. 24) further rising edges, whatever `si` carries.
- R3: The first falling `sck` edge after the last filler bit raises `so_en` and drives bit 7 of byte 0. Each later falling edge drives the next bit, MSB first within a byte, with bytes in ascending order. Every output change becomes visible one system clock after the sampled edge.
- R4: With `USE_BUS`=1, byte i is `reg_bus[8i+7:8i]`. With `USE_BUS`=0, byte i is (i*37 + `SEED`) mod 256, and `reg_bus` is ignored.
- R5: Once all `REG_BYTES` bytes have been sent, every further falling edge drives 1 on `so`, and byte 0 is not repeated.
- R6: A high `cs_n` ends the operation at any point. `so_en` is low one system clock later and `so` floats, and the next selection starts again at the command byte and byte 0.
- R7: A command other than `OPCODE` keeps `so_en` low, whatever further `sck` edges arrive, until `cs_n` goes high.
- R8: After reset (`rst_n` low), `so_en` is low.
- R9: Once raised, `so_en` stays high for as long as `cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| reg_bus | input | REG_BYTES*8 | Register contents, byte i at bits 8i+7..8i (used when USE_BUS=1) |
| so | output | 1 | Serial data to the host, high impedance while not driven |
| so_en | output | 1 | High while `so` is driven |

## Verification
The bench builds two copies that share the serial pins. The first has `USE_BUS`=1 and only `REG_BYTES`=8, so a ten-byte read runs past the end of the register, and the ones that follow can be checked against bench-chosen bus contents. The second keeps the defaults (128 bytes, contents computed from `SEED`), which covers the generated-content variant during the same transfers. Every output bit of both copies is compared at the rising edge where a host would sample it, across an aborted read followed by a restart and a rejected command.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

   typedef enum logic [1:0] {
      ST_CMD    = 2'd0,
      ST_FILLER = 2'd1,
      ST_DATA   = 2'd2,
      ST_REJECT = 2'd3
   } rd_state_t;

   // Fixed register pattern used when no bus supplies the contents
   function automatic logic [7:0] rom_byte(int unsigned idx, logic [7:0] seed);
      logic [7:0] mul;
      mul = 8'(idx * 37);
      return mul + seed;
   endfunction

endpackage

// File: rtl/secreg_edge.sv
module secreg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   output logic rise,
   output logic fall
);
   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck;
   end

   assign rise = sck & ~sck_q;
   assign fall = ~sck & sck_q;
endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
   import secreg_pkg::*;
#(
   parameter logic [7:0] OPCODE      = 8'h77,
   parameter int         DUMMY_BYTES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rise,
   input  logic si,
   output logic data_phase,
   output logic rejected
);
   localparam int DUMMY_BITS = DUMMY_BYTES * 8;
   localparam int CNT_MAX    = (DUMMY_BITS > 8) ? DUMMY_BITS : 8;
   localparam int CW         = $clog2(CNT_MAX) + 1;

   rd_state_t  st;
   logic [CW-1:0] cnt;
   logic [7:0]    sh;
   logic [7:0]    cmd_next;

   assign cmd_next = {sh[6:0], si};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_CMD;
         cnt <= '0;
         sh  <= '0;
      end else if (cs_n) begin
         st  <= ST_CMD;
         cnt <= '0;
         sh  <= '0;
      end else if (rise) begin
         case (st)
            ST_CMD: begin
               sh <= cmd_next;
               if (cnt == CW'(7)) begin
                  cnt <= '0;
                  st  <= (cmd_next == OPCODE) ? ST_FILLER : ST_REJECT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_FILLER: begin
               if (cnt == CW'(DUMMY_BITS - 1)) begin
                  cnt <= '0;
                  st  <= ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign data_phase = (st == ST_DATA);
   assign rejected   = (st == ST_REJECT);
endmodule

// File: rtl/secreg_content.sv
module secreg_content
   import secreg_pkg::*;
#(
   parameter int         REG_BYTES = 128,
   parameter bit         USE_BUS   = 1'b0,
   parameter logic [7:0] SEED      = 8'h5A
) (
   input  logic [REG_BYTES*8-1:0] reg_bus,
   output logic [REG_BYTES*8-1:0] contents
);
   generate
      if (USE_BUS) begin : g_bus
         assign contents = reg_bus;
      end else begin : g_rom
         logic unused_bus;
         assign unused_bus = ^reg_bus;
         for (genvar i = 0; i < REG_BYTES; i++) begin : g_byte
            assign contents[i*8 +: 8] = rom_byte(i, SEED);
         end
      end
   endgenerate
endmodule

// File: rtl/secreg_tx.sv
module secreg_tx #(
   parameter int REG_BYTES = 128
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   data_phase,
   input  logic                   fall,
   input  logic [REG_BYTES*8-1:0] contents,
   output logic                   tx_d,
   output logic                   tx_en
);
   localparam int TOTAL = REG_BYTES * 8;
   localparam int IW    = $clog2(TOTAL + 1);
   localparam int PW    = $clog2(TOTAL);

   logic [IW-1:0] idx;
   logic [PW-1:0] pos;

   // MSB of each byte first: flip the low three bits of the bit index
   assign pos = PW'({idx[IW-1:3], ~idx[2:0]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         tx_d  <= 1'b0;
         tx_en <= 1'b0;
      end else if (cs_n) begin
         idx   <= '0;
         tx_d  <= 1'b0;
         tx_en <= 1'b0;
      end else if (data_phase && fall) begin
         tx_en <= 1'b1;
         if (idx < IW'(TOTAL)) begin
            tx_d <= contents[pos];
            idx  <= idx + 1'b1;
         end else begin
            tx_d <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/secreg_spi_reader.sv
module secreg_spi_reader #(
   parameter int         REG_BYTES   = 128,
   parameter int         DUMMY_BYTES = 3,
   parameter logic [7:0] OPCODE      = 8'h77,
   parameter bit         USE_BUS     = 1'b0,
   parameter logic [7:0] SEED        = 8'h5A
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   sck,
   input  logic                   si,
   input  logic [REG_BYTES*8-1:0] reg_bus,
   output logic                   so,
   output logic                   so_en
);
   generate
      if (REG_BYTES < 1) begin : g_bad_bytes
         $error("REG_BYTES must be at least 1");
      end
      if (DUMMY_BYTES < 1) begin : g_bad_dummy
         $error("DUMMY_BYTES must be at least 1");
      end
   endgenerate

   logic rise, fall;
   logic data_phase, rejected;
   logic tx_d;
   logic [REG_BYTES*8-1:0] contents;

   secreg_edge i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sck   (sck),
      .rise  (rise),
      .fall  (fall)
   );

   secreg_ctrl #(
      .OPCODE      (OPCODE),
      .DUMMY_BYTES (DUMMY_BYTES)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .rise       (rise),
      .si         (si),
      .data_phase (data_phase),
      .rejected   (rejected)
   );

   secreg_content #(
      .REG_BYTES (REG_BYTES),
      .USE_BUS   (USE_BUS),
      .SEED      (SEED)
   ) i_content (
      .reg_bus  (reg_bus),
      .contents (contents)
   );

   secreg_tx #(
      .REG_BYTES (REG_BYTES)
   ) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .data_phase (data_phase),
      .fall       (fall),
      .contents   (contents),
      .tx_d       (tx_d),
      .tx_en      (so_en)
   );

   assign so = so_en ? tx_d : 1'bz;
endmodule

// File: rtl/secreg_spi_reader_chk.sv
module secreg_spi_reader_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic so_en,
   input logic so_d,
   input logic rejected
);
   // R6
   deselect_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !so_en);

   // R3
   enable_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_en) |-> ($past(sck) == 1'b0 && $past(cs_n) == 1'b0));

   // R3
   data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (so_en && $past(so_en) && so_d != $past(so_d)) |-> $past(sck) == 1'b0);

   // R7
   reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rejected && !cs_n) |=> !so_en);

   // R9
   enable_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (so_en && !cs_n) |=> so_en);
endmodule

bind secreg_spi_reader secreg_spi_reader_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sck      (sck),
   .so_en    (so_en),
   .so_d     (tx_d),
   .rejected (rejected)
);

// File: tb/test_secreg_spi_reader.sv
module test_secreg_spi_reader;
   localparam int A_BYTES = 8;
   localparam int B_BYTES = 128;
   localparam logic [7:0] B_SEED = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic si = 1'b0;
   logic [A_BYTES*8-1:0] bus_a;
   logic [B_BYTES*8-1:0] bus_b = '0;
   logic so_a, en_a, so_b, en_b;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   bit qa[$];
   bit qb[$];

   always #10 clk = ~clk;

   secreg_spi_reader #(.REG_BYTES(A_BYTES), .USE_BUS(1'b1)) i_secreg_spi_reader (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .reg_bus(bus_a), .so(so_a), .so_en(en_a));

   secreg_spi_reader #(.REG_BYTES(B_BYTES), .USE_BUS(1'b0), .SEED(B_SEED)) i_secreg_spi_reader_rom (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .reg_bus(bus_b), .so(so_b), .so_en(en_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit exp_a(int k);
      int byt = k / 8;
      if (byt >= A_BYTES) return 1'b1;  // R5
      return bus_a[byt*8 + (7 - k % 8)];
   endfunction

   function automatic bit exp_b(int k);
      int byt = k / 8;
      logic [7:0] v;
      if (byt >= B_BYTES) return 1'b1;
      v = 8'((byt * 37 + int'(B_SEED)) % 256);  // R4
      return v[7 - k % 8];
   endfunction

   // Monitor: host-side sampling on the rising serial clock
   always @(posedge sck) begin
      if (mon_on) begin
         bit ea, eb;
         if (qa.size() == 0 || qb.size() == 0) begin
            chk(1'b0, "R3 queue empty", 0, 1);
         end else begin
            ea = qa.pop_front();
            eb = qb.pop_front();
            chk(en_a && en_b, "R3 enable during data", {en_a, en_b}, 3);
            chk(so_a == ea, "R4/R5 bus copy bit", so_a, ea);
            chk(so_b == eb, "R4 seeded copy bit", so_b, eb);
         end
      end
   end

   task automatic pulse(input bit b);
      @(negedge clk);
      si = b;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) pulse(v[i]);
   endtask

   task automatic deselect();
      @(negedge clk);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!en_a && !en_b, "R6 deselect floats", {en_a, en_b}, 0);
   endtask

   // Driver: header, then nbits data bits with expectations queued
   task automatic do_read(input logic [7:0] op, input int nbits);
      @(negedge clk);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      send_byte(op);
      chk(!en_a, "R1 quiet during command", en_a, 0);
      if (op != 8'h77) begin
         for (int i = 0; i < 40; i++) pulse(i[0]);
         repeat (3) @(negedge clk);
         chk(!en_a && !en_b, "R7 rejected command", {en_a, en_b}, 0);
      end else begin
         send_byte(8'hA5);
         send_byte(8'hFF);
         send_byte(8'h3C);
         chk(!en_a && !en_b, "R2 quiet through filler", {en_a, en_b}, 0);
         mon_on = 1'b1;
         for (int k = 0; k < nbits; k++) begin
            qa.push_back(exp_a(k));
            qb.push_back(exp_b(k));
            pulse(k[1]);
         end
         repeat (2) @(negedge clk);
         mon_on = 1'b0;
         chk(en_a, "R9 enable held while selected", en_a, 1);
      end
   endtask

   initial begin
      for (int i = 0; i < A_BYTES; i++) bus_a[i*8 +: 8] = 8'(i * 29 + 8'hC3);
      repeat (3) @(negedge clk);
      chk(!en_a && !en_b, "R8 reset state", {en_a, en_b}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!en_a && !en_b, "R8 idle after reset", {en_a, en_b}, 0);

      // R1 R3 R4 R5: read past the end of the short register
      do_read(8'h77, (A_BYTES + 2) * 8);
      deselect();

      // R7: wrong command
      do_read(8'h78, 0);
      deselect();

      // R6: abort mid-byte, then restart from byte 0
      do_read(8'h77, 19);
      deselect();
      bus_a[7:0] = 8'h81;
      do_read(8'h77, 24);
      deselect();

      // R1: command with one bit off in the MSB
      do_read(8'hF7, 0);
      deselect();

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule